// File: doc/BRIEF.md
# Decade Reference Divider with Selectable Tap

This block turns a 1 MHz crystal-derived clock into the reference clock for a phase-locked loop. A chain of decade counters, all running on the input clock, splits the input rate by ten per stage. Each stage advances only when the stage below it wraps from 9 to 0. The wrap of the second stage gives a 10 kHz tick. The wrap of the third stage gives a 1 kHz tick.

A select input picks one of the two ticks to drive a toggle flop, which halves the chosen rate. The result is a square-wave reference at either 0.5 kHz or 5 kHz with 50% duty. Both raw ticks are also brought out as one-cycle pulses for use elsewhere in the loop. Everything is synchronous to the input clock, and a synchronous reset restarts the chain.

Top module: `ref_divider`

## Requirements
- R1: While `rst` is high at a clock edge, every decade counter and `ref_out` are cleared. In the cycle that follows, `tick_10k`, `tick_1k` and `ref_out` are all 0.
- R2: `tick_10k` is a single-cycle pulse once every 100 input clocks. Its first pulse appears in the 100th cycle after reset is released.
- R3: `tick_1k` is a single-cycle pulse once every 1000 input clocks. Its first pulse appears in the 1000th cycle after reset is released.
- R4: Every `tick_1k` pulse falls in the same cycle as a `tick_10k` pulse.
- R5: With `tap_sel` = 0, `ref_out` inverts at the clock edge following each `tick_1k` pulse. It is therefore a square wave with a period of 2000 input clocks and 50% duty.
- R6: With `tap_sel` = 1, `ref_out` inverts at the clock edge following each `tick_10k` pulse. The period is then 200 input clocks.
- R7: A change of `tap_sel` does not move `ref_out` by itself. `ref_out` holds its level until the next pulse of the newly selected tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz input clock shared by all stages |
| rst | input | 1 | Synchronous reset, active high |
| tap_sel | input | 1 | 0 selects the 1 kHz tick, 1 selects the 10 kHz tick |
| tick_10k | output | 1 | One-cycle pulse at 10 kHz |
| tick_1k | output | 1 | One-cycle pulse at 1 kHz |
| ref_out | output | 1 | Halved square-wave reference |

## Verification
The bench runs long spans with `tap_sel` held at 0 and then at 1. These spans separate the 2000-cycle and 200-cycle reference periods, and they confirm that each raw tick keeps its own spacing whichever tap is selected. The select is then flipped at points that fall between pulses. These flips show that the reference holds its level until a pulse of the new tap, rather than jumping at the flip. A reset asserted in the middle of a run checks that the chain restarts from zero and that the first pulses come out at their full distance.

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int RADIX    = 10,
  parameter int STAGES   = 3,
  parameter int FAST_TAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tap_sel,
  output logic tick_10k,
  output logic tick_1k,
  output logic ref_out
);
  localparam int CW = $clog2(RADIX);

  logic [STAGES:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [CW-1:0] cnt;
    logic          wrap;
    assign wrap = carry[i] && (cnt == CW'(RADIX - 1));
    assign carry[i+1] = wrap;

    always_ff @(posedge clk) begin
      if (rst)           cnt <= '0;
      else if (carry[i]) cnt <= wrap ? '0 : cnt + CW'(1);
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt < CW'(RADIX));
  end

  assign tick_10k = carry[FAST_TAP];
  assign tick_1k  = carry[STAGES];

  logic pick;
  assign pick = tap_sel ? tick_10k : tick_1k;

  always_ff @(posedge clk) begin
    if (rst)       ref_out <= 1'b0;
    else if (pick) ref_out <= ~ref_out;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!ref_out && !tick_10k && !tick_1k));

  // R2
  fast_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_10k |=> !tick_10k);

  // R3
  slow_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_1k |=> !tick_1k);

  // R7
  ref_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ref_out)) |-> $past(tap_sel ? tick_10k : tick_1k));
endmodule

// File: tb/ref_divider_tb.sv
module ref_divider_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tap_sel = 1'b0;
  logic tick_10k, tick_1k, ref_out;

  always #5 clk = ~clk;

  ref_divider u_dut (
    .clk(clk), .rst(rst), .tap_sel(tap_sel),
    .tick_10k(tick_10k), .tick_1k(tick_1k), .ref_out(ref_out)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model: phase counter modulo 1000 and expected reference level
  int  m = 0;
  bit  mref = 1'b0;
  bit  in_rst = 1'b1;
  bit  exp10, exp1;

  always @(posedge clk) begin
    if (rst) begin
      m = 0; mref = 1'b0; in_rst = 1'b1;
    end else begin
      if (tap_sel ? (m % 100 == 99) : (m == 999)) mref = ~mref;
      m = (m + 1) % 1000;
      in_rst = 1'b0;
    end
    exp10 = (m % 100 == 99);
    exp1  = (m == 999);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int  cyc = 0;
  int  last10 = -1, last1 = -1, lastref = -1;
  bit  sel_prev = 1'b0, sel_moved = 1'b0, ref_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (in_rst) begin
      check(tick_10k == 1'b0, "R1 tick_10k", tick_10k, 0);
      check(tick_1k  == 1'b0, "R1 tick_1k", tick_1k, 0);
      check(ref_out  == 1'b0, "R1 ref_out", ref_out, 0);
      last10 = -1; last1 = -1; lastref = -1;
      ref_prev = 1'b0; sel_moved = 1'b1;
    end else begin
      check(tick_10k == exp10, "R2 tick_10k", tick_10k, exp10);
      check(tick_1k  == exp1,  "R3 tick_1k", tick_1k, exp1);
      check(ref_out  == mref,  "R7 ref_out level", ref_out, mref);
      if (tick_1k) check(tick_10k, "R4 coincidence", tick_10k, 1);
      if (tick_10k) begin
        if (last10 >= 0) check(cyc - last10 == 100, "R2 spacing", cyc - last10, 100);
        last10 = cyc;
      end
      if (tick_1k) begin
        if (last1 >= 0) check(cyc - last1 == 1000, "R3 spacing", cyc - last1, 1000);
        last1 = cyc;
      end
      if (tap_sel != sel_prev) sel_moved = 1'b1;
      if (ref_out != ref_prev) begin
        if (lastref >= 0 && !sel_moved) begin
          if (tap_sel) check(cyc - lastref == 100, "R6 half period", cyc - lastref, 100);
          else         check(cyc - lastref == 1000, "R5 half period", cyc - lastref, 1000);
        end
        lastref = cyc;
        sel_moved = 1'b0;
      end
      ref_prev = ref_out;
    end
    sel_prev = tap_sel;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        step(3);
        rst = 1'b0;
        step(4600);          // R5: 1 kHz tap
        tap_sel = 1'b1;      // R7: flip between pulses
        step(730);           // R6: 10 kHz tap
        tap_sel = 1'b0;      // R7: back to slow tap mid-run
        step(2450);
        rst = 1'b1;          // R1: reset mid-run
        step(2);
        rst = 1'b0;
        tap_sel = 1'b1;
        step(1210);
        tap_sel = 1'b0;
        step(1050);
      end
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule